// File: doc/BRIEF.md
# Register-Based Page Translation Unit

This block turns a 16-bit virtual address into a 15-bit physical address through a single-level page table held entirely in flip-flops, one entry per virtual page. Each entry stores a physical frame number and a present flag. Software loads the entries through a write port, one entry per clock, typically when a process is started or switched in. After that, no memory access is needed to translate.

A lookup is a request strobe plus a virtual address. One cycle later the block returns a response. The response either carries the physical address, formed from the entry's frame number and the unchanged byte offset, or raises a fault flag when the page is marked absent. On a fault the full virtual address is kept in a status register until the next fault occurs. A flush input marks every page absent in a single cycle, which models a context switch.

Top module: `pgmap_unit`

## Requirements
- R1: The virtual address splits into a page index (bits 15:12, 16 pages) and a byte offset (bits 11:0, 4096-byte pages). The offset appears unchanged in bits 11:0 of the physical address.
- R2: For a present page, `rsp_paddr` is the entry's 3-bit frame number in bits 14:12, followed by the offset.
- R3: A lookup of a page whose present flag is clear gives `rsp_fault`=1 and `rsp_paddr`=0. Fault and a nonzero address never appear together.
- R4: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. When `rsp_valid` is low, `rsp_fault` and `rsp_paddr` are 0.
- R5: With page 0→frame 2, page 1→frame 1, page 2→frame 6, page 3→frame 0, page 5→frame 3, and pages 4 and 15 absent, address 0 gives 8192 and address 20500 gives 12308. Addresses 16384 and 61440 fault.
- R6: A table write (`tbl_we`) updates one entry at the clock edge. A lookup in the same cycle as a write to the same entry uses the entry's old contents.
- R7: On a faulting response, `fault_vaddr` holds the 16-bit address of that lookup, in the same cycle as the response. It keeps its value otherwise and is 0 after reset.
- R8: `flush` clears every present flag at the next edge. It takes priority over a write in the same cycle, which is then dropped. A lookup in the flush cycle still uses the old table.
- R9: After reset every page is absent and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Write one page table entry |
| tbl_page | input | 4 | Page index being written |
| tbl_frame | input | 3 | Frame number to store |
| tbl_present | input | 1 | Present flag to store |
| flush | input | 1 | Mark all pages absent |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_fault | output | 1 | Page fault on this response |
| rsp_paddr | output | 15 | Translated physical address |
| fault_vaddr | output | 16 | Virtual address of the most recent fault |

## Verification
The assertions assume that every input is defined and held steady around each rising edge. They also assume that `tbl_page` is meaningful only while `tbl_we` is high. The write-visibility property reads `tbl_page` one cycle back only when a write without a flush took place. The bench changes inputs only on falling edges and deasserts every strobe between operations unless the operation needs it. It overlaps writes, flushes and lookups only in the deliberate collision cases.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int unsigned PG_VA_W    = 16;
  localparam int unsigned PG_OFF_W   = 12;
  localparam int unsigned PG_FRAME_W = 3;
endpackage

// File: rtl/pgmap_table.sv
module pgmap_table #(
  parameter int unsigned PAGE_W  = 4,
  parameter int unsigned FRAME_W = 3,
  localparam int unsigned NPAGES = 1 << PAGE_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [PAGE_W-1:0]                wpage,
  input  logic [FRAME_W-1:0]               wframe,
  input  logic                             wpresent,
  input  logic                             flush,
  output logic [NPAGES-1:0][FRAME_W-1:0]   frame_q,
  output logic [NPAGES-1:0]                present_q
);
  for (genvar g = 0; g < NPAGES; g++) begin : g_entry
    logic hit_w;
    assign hit_w = we && !flush && (wpage == PAGE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frame_q[g]   <= '0;
        present_q[g] <= 1'b0;
      end else if (flush) begin
        present_q[g] <= 1'b0;
      end else if (hit_w) begin
        frame_q[g]   <= wframe;
        present_q[g] <= wpresent;
      end
    end
  end
endmodule

// File: rtl/pgmap_lookup.sv
module pgmap_lookup #(
  parameter int unsigned VA_W    = 16,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned FRAME_W = 3,
  localparam int unsigned PAGE_W = VA_W - OFF_W,
  localparam int unsigned NPAGES = 1 << PAGE_W,
  localparam int unsigned PA_W   = FRAME_W + OFF_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [VA_W-1:0]                req_vaddr,
  input  logic [NPAGES-1:0][FRAME_W-1:0] frame_tbl,
  input  logic [NPAGES-1:0]              present_tbl,
  output logic                           miss_now,
  output logic                           rsp_valid,
  output logic                           rsp_fault,
  output logic [PA_W-1:0]                rsp_paddr
);
  function automatic logic [PAGE_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [FRAME_W-1:0] fr,
                                              input logic [OFF_W-1:0] off);
    return {fr, off};
  endfunction

  logic [PAGE_W-1:0] pg_w;
  logic              pres_w;
  logic [PA_W-1:0]   pa_w;

  assign pg_w     = page_of(req_vaddr);
  assign pres_w   = present_tbl[pg_w];
  assign pa_w     = join_pa(frame_tbl[pg_w], offset_of(req_vaddr));
  assign miss_now = req_valid && !pres_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= miss_now;
      rsp_paddr <= (req_valid && pres_w) ? pa_w : '0;
    end
  end
endmodule

// File: rtl/pgmap_fault_reg.sv
module pgmap_fault_reg #(
  parameter int unsigned VA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [VA_W-1:0] vaddr_in,
  output logic [VA_W-1:0] vaddr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vaddr_q <= '0;
    else if (capture) vaddr_q <= vaddr_in;
  end
endmodule

// File: rtl/pgmap_unit.sv
module pgmap_unit
  import pgmap_pkg::*;
#(
  parameter int unsigned VA_W    = PG_VA_W,
  parameter int unsigned OFF_W   = PG_OFF_W,
  parameter int unsigned FRAME_W = PG_FRAME_W,
  localparam int unsigned PAGE_W = VA_W - OFF_W,
  localparam int unsigned NPAGES = 1 << PAGE_W,
  localparam int unsigned PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [PAGE_W-1:0]  tbl_page,
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic               tbl_present,
  input  logic               flush,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [VA_W-1:0]    fault_vaddr
);
  logic [NPAGES-1:0][FRAME_W-1:0] frame_vec;
  logic [NPAGES-1:0]              present_vec;
  logic                           miss_now;

  pgmap_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) table_i (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .wpage(tbl_page),
    .wframe(tbl_frame), .wpresent(tbl_present), .flush(flush),
    .frame_q(frame_vec), .present_q(present_vec)
  );

  pgmap_lookup #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) lookup_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .frame_tbl(frame_vec), .present_tbl(present_vec), .miss_now(miss_now),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  pgmap_fault_reg #(.VA_W(VA_W)) fault_i (
    .clk(clk), .rst_n(rst_n), .capture(miss_now),
    .vaddr_in(req_vaddr), .vaddr_q(fault_vaddr)
  );
endmodule

// File: rtl/pgmap_checker.sv
module pgmap_checker #(
  parameter int unsigned VA_W    = 16,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned FRAME_W = 3,
  localparam int unsigned PAGE_W = VA_W - OFF_W,
  localparam int unsigned NPAGES = 1 << PAGE_W,
  localparam int unsigned PA_W   = FRAME_W + OFF_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tbl_we,
  input logic [PAGE_W-1:0]  tbl_page,
  input logic               tbl_present,
  input logic               flush,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_vaddr,
  input logic               rsp_valid,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [VA_W-1:0]    fault_vaddr,
  input logic [NPAGES-1:0]  present_vec
);
  a_r4_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == '0));

  a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_paddr == '0));

  a_r7_fault_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (fault_vaddr == $past(req_vaddr)));

  a_r7_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> $stable(fault_vaddr));

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (present_vec == '0));

  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !flush) |=> (present_vec[$past(tbl_page)] == $past(tbl_present)));
endmodule

bind pgmap_unit pgmap_checker #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_page(tbl_page),
  .tbl_present(tbl_present), .flush(flush), .req_valid(req_valid),
  .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .fault_vaddr(fault_vaddr), .present_vec(present_vec)
);

// File: tb/pgmap_unit_tb_top.sv
module pgmap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_page = '0;
  logic [2:0]  tbl_frame = '0;
  logic        tbl_present = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [14:0] rsp_paddr;
  logic [15:0] fault_vaddr;

  int checks = 0;
  int fails  = 0;

  int ref_frame [16];
  bit ref_pres  [16];
  int exp_v = 0, exp_f = 0, exp_pa = 0, exp_fva = 0;

  always #10 clk = ~clk;

  pgmap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_page(tbl_page),
    .tbl_frame(tbl_frame), .tbl_present(tbl_present), .flush(flush),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .fault_vaddr(fault_vaddr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model reacts to the inputs seen at the edge, then all outputs compared
  task automatic step();
    @(posedge clk);
    if (req_valid) begin
      int pg = int'(req_vaddr) / 4096;
      exp_v = 1;
      if (ref_pres[pg]) begin
        exp_f  = 0;
        exp_pa = ref_frame[pg] * 4096 + int'(req_vaddr) % 4096;
      end else begin
        exp_f   = 1;
        exp_pa  = 0;
        exp_fva = int'(req_vaddr);
      end
    end else begin
      exp_v = 0; exp_f = 0; exp_pa = 0;
    end
    if (flush) foreach (ref_pres[i]) ref_pres[i] = 0;
    else if (tbl_we) begin
      ref_frame[int'(tbl_page)] = int'(tbl_frame);
      ref_pres[int'(tbl_page)]  = tbl_present;
    end
    @(negedge clk);
    chk("R4 rsp_valid", int'(rsp_valid), exp_v);
    chk("R3 rsp_fault", int'(rsp_fault), exp_f);
    chk("R2 rsp_paddr", int'(rsp_paddr), exp_pa);
    chk("R7 fault_vaddr", int'(fault_vaddr), exp_fva);
  endtask

  task automatic load(input int pg, input int fr, input bit pr);
    tbl_we = 1'b1; tbl_page = 4'(pg); tbl_frame = 3'(fr); tbl_present = pr;
    step();
    tbl_we = 1'b0;
  endtask

  task automatic look(input int va);
    req_valid = 1'b1; req_vaddr = 16'(va);
    step();
    req_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    foreach (ref_pres[i]) begin ref_pres[i] = 0; ref_frame[i] = 0; end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 rsp_valid", int'(rsp_valid), 0);
    chk("R9 rsp_paddr", int'(rsp_paddr), 0);
    chk("R9 fault_vaddr", int'(fault_vaddr), 0);
    rst_n = 1'b1;
    step();
    look(16'h1234);
    chk("R9 empty table faults", int'(rsp_fault), 1);

    // R5 worked example table
    load(0, 2, 1); load(1, 1, 1); load(2, 6, 1); load(3, 0, 1);
    load(4, 7, 0); load(5, 3, 1); load(15, 5, 0);
    look(0);
    chk("R5 va 0", int'(rsp_paddr), 8192);
    look(20500);
    chk("R5 va 20500", int'(rsp_paddr), 12308);
    look(16384);
    chk("R5 page 4 faults", int'(rsp_fault), 1);
    look(61440);
    chk("R5 page 15 faults", int'(rsp_fault), 1);
    chk("R7 captured 61440", int'(fault_vaddr), 61440);
    look(4095);
    chk("R7 holds after hit", int'(fault_vaddr), 61440);
    chk("R1 offset passes", int'(rsp_paddr) % 4096, 4095);

    // R6: write and lookup of the same entry in one cycle
    tbl_we = 1'b1; tbl_page = 4'd4; tbl_frame = 3'd5; tbl_present = 1'b1;
    req_valid = 1'b1; req_vaddr = 16'h4010;
    step();
    tbl_we = 1'b0; req_valid = 1'b0;
    chk("R6 old entry used", int'(rsp_fault), 1);
    look(16'h4010);
    chk("R6 new entry visible", int'(rsp_paddr), 5 * 4096 + 16);

    // R8: flush with a same-cycle write and lookup
    flush = 1'b1; tbl_we = 1'b1; tbl_page = 4'd9; tbl_frame = 3'd4; tbl_present = 1'b1;
    req_valid = 1'b1; req_vaddr = 16'h2abc;
    step();
    flush = 1'b0; tbl_we = 1'b0; req_valid = 1'b0;
    chk("R8 lookup in flush cycle uses old table", int'(rsp_paddr), 6 * 4096 + 16'habc);
    look(16'h2abc);
    chk("R8 flushed page faults", int'(rsp_fault), 1);
    look(16'h9000);
    chk("R8 write during flush dropped", int'(rsp_fault), 1);

    // R1/R2 sweep over random tables and addresses
    for (int n = 0; n < 400; n++) begin
      int va;
      tbl_we = ($urandom % 3) == 0;
      tbl_page = 4'($urandom); tbl_frame = 3'($urandom); tbl_present = 1'($urandom % 4 != 0);
      flush = ($urandom % 40) == 0;
      req_valid = ($urandom % 4) != 0;
      va = int'($urandom % 65536);
      req_vaddr = 16'(va);
      step();
      if (rsp_valid && !rsp_fault)
        chk("R1 offset unchanged", int'(rsp_paddr) % 4096, exp_pa % 4096);
    end
    tbl_we = 1'b0; flush = 1'b0; req_valid = 1'b0;
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule